// File: doc/BRIEF.md
# Raw Display Horizontal Pixel Sequencer

This block produces the horizontal part of a raw video output, one in which no timing codes are embedded in the data. A sub-pixel phase counter divides the video clock so that one pixel lasts a programmable number of clocks. A frame-pixel counter walks across each line, covering the active width and then the horizontal blanking. An image-pixel counter tracks the picture window placed inside the active region. One value leaves on the output bus every clock. That value is the blanking constant, the default (border) constant or a word read from the pixel FIFO. A single control pin carries either a horizontal blanking strobe or a horizontal sync pulse, with selectable polarity.

Vertical timing comes from outside through a line-valid input, which is sampled once per line. Line geometry, window placement and clocks per pixel are static configuration inputs. The two constants and line-valid are captured at the first clock of every line. The data, control pin and underflow flag reach the outputs a fixed two clocks after the counter state they describe. The FIFO read strobe is issued in the same cycle as that state, and the FIFO word is taken on the following edge. The FIFO storage itself lies outside the block.

Top module: `raw_disp_hseq`

## Requirements
- R1: While reset is asserted, and for the first two clocks after it is released, vout_data, vout_ctl and vout_uflow are 0. Right after reset, the pixel counter is at pixel 0, phase 0.
- R2: One pixel lasts cfg_cpp clocks, and a cfg_cpp value of 0 is treated as 1. The pixel counter runs from 0 to cfg_act_width+cfg_hblank_len-1 and then wraps to 0. Pixels below cfg_act_width are the active region.
- R3: vout_data, vout_ctl and vout_uflow describe the counter state of two rising edges earlier. fifo_rd is combinational from the current counter state, and fifo_data is captured on the next rising edge.
- R4: The blanking constant is output for every clock of a blanking pixel, and for every clock of a line whose sampled line_valid was 0.
- R5: In the active region of a valid line, and outside the image window, the default constant is output.
- R6: The image window starts at pixel cfg_img_off, where the image counter is 0. It ends after cfg_img_size pixels or at the end of the active region, whichever comes first. A size of 0 gives no window. Inside the window fifo_rd is 1 on every clock, and the FIFO word is output.
- R7: cfg_blank_val, cfg_dflt_val and line_valid are sampled only at the first clock of a line (pixel 0, phase 0). Changes to them later in the line have no effect on that line's output.
- R8: A window clock with fifo_empty=1 raises vout_uflow in the output cycle of that clock, and the default constant is output instead of FIFO data.
- R9: With cfg_ctl_sel=0 the control pin is asserted for pixels at or beyond cfg_act_width, so its inactive edge falls on pixel 0. With cfg_ctl_sel=1 it is asserted for pixels p with cfg_hs_start <= p < cfg_hs_stop.
- R10: With cfg_ctl_inv=1 the asserted control level is 0. With cfg_ctl_inv=0 it is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Video clock |
| rst_n | input | 1 | Asynchronous active-low reset, deasserted synchronously |
| cfg_cpp | input | CPP_W | Clocks per pixel (0 treated as 1) |
| cfg_act_width | input | CNT_W | Active pixels per line |
| cfg_hblank_len | input | CNT_W | Blanking pixels per line |
| cfg_img_off | input | CNT_W | First window pixel |
| cfg_img_size | input | CNT_W | Window width in pixels |
| cfg_hs_start | input | CNT_W | First sync pixel |
| cfg_hs_stop | input | CNT_W | First pixel after sync |
| cfg_ctl_sel | input | 1 | Control pin source: 0 blanking, 1 sync |
| cfg_ctl_inv | input | 1 | Control pin active-low when 1 |
| cfg_blank_val | input | DW | Blanking constant |
| cfg_dflt_val | input | DW | Border constant |
| line_valid | input | 1 | Line carries active video (sampled at line start) |
| fifo_data | input | DW | FIFO word, valid with fifo_rd |
| fifo_empty | input | 1 | FIFO has no word |
| fifo_rd | output | 1 | FIFO read strobe |
| vout_data | output | DW | Output data bus |
| vout_ctl | output | 1 | Shared blanking/sync pin |
| vout_uflow | output | 1 | Underflow flag, aligned with vout_data |

## Verification
A counter that slips by one clock in the phase divider moves every later control-pin edge and every constant-to-FIFO transition. The per-clock comparison then reports the fault within one pixel of the slip. A window counter stopped at the wrong count shows up at the window end, where FIFO words continue or stop early, and fifo_rd shows it on the same clock. A fault in the line-start sampling shows up only in the line after the constant or line_valid changes. The random mid-line changes reach that case within a few lines.

// File: rtl/rdo_pkg.sv
package rdo_pkg;
  typedef enum logic [1:0] {
    SRC_BLANK = 2'd0,
    SRC_DFLT  = 2'd1,
    SRC_FIFO  = 2'd2
  } src_e;
endpackage

// File: rtl/rdo_pix_phase.sv
// Sub-pixel phase divider: one pixel enable every cfg_cpp clocks.
module rdo_pix_phase #(
  parameter int CPP_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CPP_W-1:0] cfg_cpp,
  output logic             pix_en,
  output logic             ph_zero
);
  localparam logic [CPP_W-1:0] PH_ONE = 1;

  logic [CPP_W-1:0] ph_q, ph_d, ph_last;

  always_comb begin
    ph_last = (cfg_cpp == '0) ? '0 : cfg_cpp - PH_ONE;
    pix_en  = (ph_q >= ph_last);
    ph_zero = (ph_q == '0);
    ph_d    = pix_en ? '0 : ph_q + PH_ONE;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ph_q <= '0;
    else        ph_q <= ph_d;
  end

  // R2
  phase_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pix_en |=> ph_zero);
endmodule

// File: rtl/rdo_line_track.sv
// Frame-pixel counter, image-pixel counter, window and line-start sampling.
module rdo_line_track #(
  parameter int CNT_W = 12,
  parameter int DW    = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             pix_en,
  input  logic             ph_zero,
  input  logic [CNT_W-1:0] cfg_act_width,
  input  logic [CNT_W-1:0] cfg_hblank_len,
  input  logic [CNT_W-1:0] cfg_img_off,
  input  logic [CNT_W-1:0] cfg_img_size,
  input  logic             line_valid,
  input  logic [DW-1:0]    cfg_blank_val,
  input  logic [DW-1:0]    cfg_dflt_val,
  output logic [CNT_W-1:0] fp_cnt,
  output logic             in_active,
  output logic             in_win,
  output logic [DW-1:0]    blank_eff,
  output logic [DW-1:0]    dflt_eff
);
  localparam logic [CNT_W-1:0] C_ONE = 1;
  localparam logic [CNT_W:0]   T_ONE = 1;

  logic [CNT_W-1:0] fp_q, fp_d, ip_q, ip_d, ip_base, size_last;
  logic [CNT_W:0]   total, last_px;
  logic             act_q, act_eff, done_q, done_d, done_base, line_start;
  logic [DW-1:0]    blank_q, dflt_q;

  // next-state
  always_comb begin
    total      = {1'b0, cfg_act_width} + {1'b0, cfg_hblank_len};
    last_px    = (total == '0) ? '0 : total - T_ONE;
    line_start = ph_zero && (fp_q == '0);
    act_eff    = line_start ? line_valid    : act_q;
    blank_eff  = line_start ? cfg_blank_val : blank_q;
    dflt_eff   = line_start ? cfg_dflt_val  : dflt_q;
    ip_base    = line_start ? '0   : ip_q;
    done_base  = line_start ? 1'b0 : done_q;
    size_last  = cfg_img_size - C_ONE;
    in_active  = act_eff && (fp_q < cfg_act_width);
    in_win     = in_active && (fp_q >= cfg_img_off) && !done_base
                 && (cfg_img_size != '0);
    ip_d       = ip_base;
    done_d     = done_base;
    if (pix_en && in_win) begin
      if (ip_base == size_last) done_d = 1'b1;
      else                      ip_d   = ip_base + C_ONE;
    end
    fp_d = fp_q;
    if (pix_en) fp_d = ({1'b0, fp_q} >= last_px) ? '0 : fp_q + C_ONE;
    fp_cnt = fp_q;
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fp_q    <= '0;
      ip_q    <= '0;
      done_q  <= 1'b0;
      act_q   <= 1'b0;
      blank_q <= '0;
      dflt_q  <= '0;
    end else begin
      fp_q    <= fp_d;
      ip_q    <= ip_d;
      done_q  <= done_d;
      act_q   <= act_eff;
      blank_q <= blank_eff;
      dflt_q  <= dflt_eff;
    end
  end

  // R2
  fp_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !pix_en |=> $stable(fp_q));
  // R6
  ip_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_win |-> (ip_base < cfg_img_size));
  // R7
  line_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !line_start |=> $stable(blank_q) && $stable(dflt_q) && $stable(act_q));
endmodule

// File: rtl/rdo_out_pipe.sv
// Source select followed by a LAT-deep register chain to the pins.
module rdo_out_pipe
  import rdo_pkg::*;
#(
  parameter int DW  = 10,
  parameter int LAT = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  src_e          src,
  input  logic [DW-1:0] blank_val,
  input  logic [DW-1:0] dflt_val,
  input  logic [DW-1:0] fifo_word,
  input  logic          ctl_in,
  input  logic          uflow_in,
  output logic [DW-1:0] data_o,
  output logic          ctl_o,
  output logic          uflow_o
);
  logic [DW-1:0] sel_data;
  logic [DW-1:0] d_q [LAT];
  logic          c_q [LAT];
  logic          u_q [LAT];

  always_comb begin
    unique case (src)
      SRC_FIFO: sel_data = fifo_word;
      SRC_DFLT: sel_data = dflt_val;
      default:  sel_data = blank_val;
    endcase
  end

  for (genvar g = 0; g < LAT; g++) begin : g_stage
    logic [DW-1:0] d_in;
    logic          c_in, u_in;
    if (g == 0) begin : g_head
      assign d_in = sel_data;
      assign c_in = ctl_in;
      assign u_in = uflow_in;
    end else begin : g_body
      assign d_in = d_q[g-1];
      assign c_in = c_q[g-1];
      assign u_in = u_q[g-1];
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        d_q[g] <= '0;
        c_q[g] <= 1'b0;
        u_q[g] <= 1'b0;
      end else begin
        d_q[g] <= d_in;
        c_q[g] <= c_in;
        u_q[g] <= u_in;
      end
    end
  end

  assign data_o  = d_q[LAT-1];
  assign ctl_o   = c_q[LAT-1];
  assign uflow_o = u_q[LAT-1];

  // R8
  uflow_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    uflow_in |-> (src == SRC_DFLT));
endmodule

// File: rtl/raw_disp_hseq.sv
module raw_disp_hseq
  import rdo_pkg::*;
#(
  parameter int DW    = 10,
  parameter int CNT_W = 12,
  parameter int CPP_W = 3,
  parameter int LAT   = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CPP_W-1:0] cfg_cpp,
  input  logic [CNT_W-1:0] cfg_act_width,
  input  logic [CNT_W-1:0] cfg_hblank_len,
  input  logic [CNT_W-1:0] cfg_img_off,
  input  logic [CNT_W-1:0] cfg_img_size,
  input  logic [CNT_W-1:0] cfg_hs_start,
  input  logic [CNT_W-1:0] cfg_hs_stop,
  input  logic             cfg_ctl_sel,
  input  logic             cfg_ctl_inv,
  input  logic [DW-1:0]    cfg_blank_val,
  input  logic [DW-1:0]    cfg_dflt_val,
  input  logic             line_valid,
  input  logic [DW-1:0]    fifo_data,
  input  logic             fifo_empty,
  output logic             fifo_rd,
  output logic [DW-1:0]    vout_data,
  output logic             vout_ctl,
  output logic             vout_uflow
);
  logic             pix_en, ph_zero, in_active, in_win, ctl_raw, uflow_now;
  logic [CNT_W-1:0] fp_cnt;
  logic [DW-1:0]    blank_eff, dflt_eff;
  src_e             src;

  rdo_pix_phase #(.CPP_W(CPP_W)) u_phase (
    .clk(clk), .rst_n(rst_n), .cfg_cpp(cfg_cpp),
    .pix_en(pix_en), .ph_zero(ph_zero)
  );

  rdo_line_track #(.CNT_W(CNT_W), .DW(DW)) u_track (
    .clk(clk), .rst_n(rst_n), .pix_en(pix_en), .ph_zero(ph_zero),
    .cfg_act_width(cfg_act_width), .cfg_hblank_len(cfg_hblank_len),
    .cfg_img_off(cfg_img_off), .cfg_img_size(cfg_img_size),
    .line_valid(line_valid), .cfg_blank_val(cfg_blank_val),
    .cfg_dflt_val(cfg_dflt_val), .fp_cnt(fp_cnt), .in_active(in_active),
    .in_win(in_win), .blank_eff(blank_eff), .dflt_eff(dflt_eff)
  );

  always_comb begin
    uflow_now = in_win && fifo_empty;
    if (!in_active)           src = SRC_BLANK;
    else if (in_win && !fifo_empty) src = SRC_FIFO;
    else                      src = SRC_DFLT;
    if (cfg_ctl_sel) ctl_raw = (fp_cnt >= cfg_hs_start) && (fp_cnt < cfg_hs_stop);
    else             ctl_raw = (fp_cnt >= cfg_act_width);
  end

  assign fifo_rd = in_win;

  rdo_out_pipe #(.DW(DW), .LAT(LAT)) u_pipe (
    .clk(clk), .rst_n(rst_n), .src(src), .blank_val(blank_eff),
    .dflt_val(dflt_eff), .fifo_word(fifo_data),
    .ctl_in(ctl_raw ^ cfg_ctl_inv), .uflow_in(uflow_now),
    .data_o(vout_data), .ctl_o(vout_ctl), .uflow_o(vout_uflow)
  );

  if (LAT == 2) begin : g_lat2_chk
    // R8
    uflow_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
      vout_uflow |-> $past(fifo_rd && fifo_empty, 2));
  end
endmodule

// File: tb/raw_disp_hseq_bench.sv
`timescale 1ns/1ps
module raw_disp_hseq_bench;
  localparam int DW = 10, CNT_W = 12, CPP_W = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [CPP_W-1:0] cfg_cpp = '0;
  logic [CNT_W-1:0] cfg_act_width = '0, cfg_hblank_len = '0, cfg_img_off = '0;
  logic [CNT_W-1:0] cfg_img_size = '0, cfg_hs_start = '0, cfg_hs_stop = '0;
  logic cfg_ctl_sel = 1'b0, cfg_ctl_inv = 1'b0, line_valid = 1'b0, fifo_empty = 1'b0;
  logic [DW-1:0] cfg_blank_val = '0, cfg_dflt_val = '0, fifo_data = '0;
  logic fifo_rd, vout_ctl, vout_uflow;
  logic [DW-1:0] vout_data;

  int n_tests = 0, n_fail = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  raw_disp_hseq u_raw_disp_hseq (
    .clk(clk), .rst_n(rst_n), .cfg_cpp(cfg_cpp), .cfg_act_width(cfg_act_width),
    .cfg_hblank_len(cfg_hblank_len), .cfg_img_off(cfg_img_off),
    .cfg_img_size(cfg_img_size), .cfg_hs_start(cfg_hs_start),
    .cfg_hs_stop(cfg_hs_stop), .cfg_ctl_sel(cfg_ctl_sel),
    .cfg_ctl_inv(cfg_ctl_inv), .cfg_blank_val(cfg_blank_val),
    .cfg_dflt_val(cfg_dflt_val), .line_valid(line_valid),
    .fifo_data(fifo_data), .fifo_empty(fifo_empty), .fifo_rd(fifo_rd),
    .vout_data(vout_data), .vout_ctl(vout_ctl), .vout_uflow(vout_uflow)
  );

  // reference model state
  int m_fp, m_ph, m_act, m_blank, m_dflt;
  int h1_d, h1_c, h1_u, h2_d, h2_c, h2_u, hv;
  string h1_t, h2_t;

  task automatic check(input string tag, input int act, input int exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d (t=%0t)", tag, act, exp, $time);
    end
  endtask

  function automatic int cpp_eff();
    return (cfg_cpp == 0) ? 1 : int'(cfg_cpp);
  endfunction

  function automatic int line_len();
    return int'(cfg_act_width) + int'(cfg_hblank_len);
  endfunction

  function automatic bit exp_win(input int fp, input int act);
    return act != 0 && fp < int'(cfg_act_width) && fp >= int'(cfg_img_off)
           && fp < int'(cfg_img_off) + int'(cfg_img_size);
  endfunction

  function automatic int exp_ctl(input int fp);
    bit a;
    a = cfg_ctl_sel ? (fp >= int'(cfg_hs_start) && fp < int'(cfg_hs_stop))
                    : (fp >= int'(cfg_act_width));
    return int'(a ^ cfg_ctl_inv);
  endfunction

  task automatic advance_model();
    if (m_ph >= cpp_eff() - 1) begin
      m_ph = 0;
      m_fp = (m_fp >= line_len() - 1) ? 0 : m_fp + 1;
    end else m_ph++;
  endtask

  task automatic drive_random();
    fifo_data  = DW'($urandom);
    fifo_empty = ($urandom_range(0, 15) == 0);
    if ($urandom_range(0, 150) == 0) line_valid = ~line_valid;
    if ($urandom_range(0, 200) == 0) cfg_blank_val = DW'($urandom);
    if ($urandom_range(0, 200) == 0) cfg_dflt_val  = DW'($urandom);
  endtask

  task automatic run_lines(input int lines);
    int cur_d, cur_c, cur_u, win;
    string cur_t;
    rst_n = 1'b0;
    repeat (3) begin
      @(negedge clk);
      check("R1 reset data", int'(vout_data), 0);
      check("R1 reset ctl", int'(vout_ctl), 0);
      check("R1 reset uflow", int'(vout_uflow), 0);
    end
    rst_n = 1'b1;
    m_fp = 0; m_ph = 0; hv = 0;
    for (int k = 0; k < line_len() * cpp_eff() * lines; k++) begin
      if (k > 0) begin
        @(negedge clk);
        advance_model();
      end
      if (hv < 2) begin
        check("R1 post-reset data", int'(vout_data), 0);
        check("R1 post-reset ctl", int'(vout_ctl), 0);
      end else begin
        check({h2_t, " R3 data"}, int'(vout_data), h2_d);
        check("R2 R9 R10 ctl", int'(vout_ctl), h2_c);
        check("R8 uflow", int'(vout_uflow), h2_u);
      end
      drive_random();
      #1;
      if (m_fp == 0 && m_ph == 0) begin   // R7 line-start sampling
        m_act = int'(line_valid); m_blank = int'(cfg_blank_val); m_dflt = int'(cfg_dflt_val);
      end
      win = exp_win(m_fp, m_act);
      check("R6 R3 fifo_rd", int'(fifo_rd), win);
      cur_u = win & int'(fifo_empty);
      cur_c = exp_ctl(m_fp);
      if (!(m_act != 0 && m_fp < int'(cfg_act_width))) begin
        cur_d = m_blank; cur_t = "R4 R7";
      end else if (win && !fifo_empty) begin
        cur_d = int'(fifo_data); cur_t = "R6";
      end else begin
        cur_d = m_dflt; cur_t = win ? "R8" : "R5 R7";
      end
      h2_d = h1_d; h2_c = h1_c; h2_u = h1_u; h2_t = h1_t;
      h1_d = cur_d; h1_c = cur_c; h1_u = cur_u; h1_t = cur_t;
      hv++;
    end
  endtask

  task automatic set_cfg(input int cpp, input int w, input int hb, input int off,
                         input int sz, input int hs0, input int hs1,
                         input bit sel, input bit inv);
    cfg_cpp = CPP_W'(cpp); cfg_act_width = CNT_W'(w); cfg_hblank_len = CNT_W'(hb);
    cfg_img_off = CNT_W'(off); cfg_img_size = CNT_W'(sz);
    cfg_hs_start = CNT_W'(hs0); cfg_hs_stop = CNT_W'(hs1);
    cfg_ctl_sel = sel; cfg_ctl_inv = inv; line_valid = 1'b1;
  endtask

  initial begin
    void'($urandom(32'h5eed_1234));
    // R2 R6: three clocks per pixel, 704-pixel window centred in 720
    set_cfg(3, 720, 138, 8, 704, 736, 800, 1'b0, 1'b1);
    run_lines(4);
    // R6: window covering the whole active region, one clock per pixel, sync pin
    set_cfg(1, 20, 8, 0, 20, 22, 26, 1'b1, 1'b0);
    run_lines(6);
    // R6: empty window
    set_cfg(2, 16, 6, 3, 0, 0, 4, 1'b1, 1'b1);
    run_lines(5);
    // R6: window clipped at end of active region
    set_cfg(2, 24, 5, 10, 40, 25, 28, 1'b0, 1'b0);
    run_lines(5);
    // R2: clocks-per-pixel 0 behaves as 1
    set_cfg(0, 12, 4, 2, 5, 13, 15, 1'b1, 1'b0);
    run_lines(6);
    for (int i = 0; i < 10; i++) begin
      int w;
      int hb;
      w  = $urandom_range(4, 40);
      hb = $urandom_range(1, 12);
      set_cfg($urandom_range(1, 4), w, hb, $urandom_range(0, w),
              $urandom_range(0, w + 4), $urandom_range(0, w + hb),
              $urandom_range(0, w + hb), 1'($urandom), 1'($urandom));
      run_lines(6);
    end
    if (!finished) begin
      finished = 1;
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      n_tests++; n_fail++;
      $display("FAIL watchdog R1: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end
endmodule